// File: doc/BRIEF.md
# Key Event Queue with Autorepeat

This block sits behind a key-matrix debouncer. Once per debounce cycle it samples a 64-bit vector of settled key states. It compares that vector with the states it has already reported, and it turns each difference into a press or release event. The events go into a 16-entry queue. A host drains the queue one byte per one-cycle read strobe.

While keys stay held and autorepeat is on, the block adds a shared repeat code to the queue, first after a programmable delay and then at a programmable rate. An interrupt request rises when the queue reaches a programmed level or when a programmed number of debounce cycles has passed since the latest queued event, whichever happens first. One configuration input chooses whether a read clears the request or whether the request stays up until the queue is drained.

Key numbering is column times 8 plus row. The vector bit with that index carries the state of that key, and 1 means held.

Top module: `key_event_queue`

## Requirements
- R1: After reset the read byte is 0x3F, the interrupt request is low and the overflow flag is low.
- R2: A popped byte holds the key number (column*8+row) in bits 5:0. Bit 6 is 0 for a press and 1 for a release. Bit 7 is 1 when at least one more entry remains in the queue after this pop.
- R3: When several keys change on the same debounce tick, their events enter the queue in ascending key-number order.
- R4: While rel_en is 0, release events are not queued; press events still are.
- R5: A read strobe on an empty queue returns 0x3F and leaves the queue unchanged.
- R6: With rep_en at 1 and at least one key held, the code 0x7E is queued on the (rep_delay+1)*8-th quiet tick after the last key event. After that it is queued every (rep_rate+1)*4 quiet ticks. Only one code is queued per interval, however many keys are held.
- R7: Any recorded key change (press or release) restarts the repeat delay phase. A release that leaves other keys held therefore leads to a fresh delay before the next 0x7E.
- R8: When irq_level is nonzero, the interrupt request rises once the queue holds at least 2*irq_level entries. When irq_level is 0, queue level does not raise it.
- R9: When irq_ticks is nonzero, the interrupt request rises on the irq_ticks-th tick after the latest queued event.
- R10: With rd_clr at 1, any read strobe clears the request. With rd_clr at 0, the request clears only on the read that empties the queue.
- R11: The queue holds 16 entries. An event that arrives while it is full is dropped and sets a sticky overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick | input | 1 | One-cycle strobe, one per debounce cycle |
| key_state | input | 64 | Debounced key states, sampled on scan_tick |
| rel_en | input | 1 | Queue release events when 1 |
| rep_en | input | 1 | Autorepeat enable |
| rep_delay | input | 4 | First repeat after (rep_delay+1)*8 ticks |
| rep_rate | input | 3 | Repeat period (rep_rate+1)*4 ticks |
| irq_ticks | input | 5 | Tick count to interrupt after an event, 0 disables |
| irq_level | input | 3 | Interrupt at 2*irq_level entries, 0 disables |
| rd_clr | input | 1 | 1: a read clears the interrupt; 0: emptying clears it |
| rd_stb | input | 1 | One-cycle read strobe, pops one entry |
| rd_data | output | 8 | Byte returned by the latest read |
| irq | output | 1 | Interrupt request, active high |
| overflow | output | 1 | Sticky queue overflow flag |

## Verification
The hardest behaviour to reach is the repeat restart: a second key is pressed, or one of two held keys is released, while a repeat sequence is running. The stimulus holds two keys until the first 0x7E and the following rate interval have been observed. It then adds a key and later releases one. After each change it counts seven quiet ticks, checks that the queue is empty, and checks that the eighth quiet tick delivers exactly one 0x7E. Overflow is reached by a single tick that changes seventeen keys at once.

// File: rtl/kq_pkg.sv
package kq_pkg;

    localparam int KEY_W     = 6;
    localparam int KEY_COUNT = 1 << KEY_W;
    localparam int Q_DEPTH   = 16;

    typedef struct packed {
        logic             release_ev;
        logic [KEY_W-1:0] key;
    } kev_t;

    localparam int EV_W = $bits(kev_t);

    localparam kev_t     REPEAT_EV  = '{release_ev: 1'b1, key: 6'h3E};
    localparam logic [7:0] IDLE_BYTE = 8'h3F;

    function automatic logic [7:0] first_wait(input logic [3:0] code);
        return ({4'd0, code} + 8'd1) << 3;
    endfunction

    function automatic logic [7:0] next_wait(input logic [2:0] code);
        return ({5'd0, code} + 8'd1) << 2;
    endfunction

endpackage

// File: rtl/kq_event_scan.sv
module kq_event_scan
    import kq_pkg::*;
#(
    parameter int KEYS = KEY_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scan_tick,
    input  logic [KEYS-1:0] key_state,
    input  logic            rel_en,
    output logic            ev_push,
    output kev_t            ev_data,
    output logic            ev_change,
    output logic            quiet_tick,
    output logic            any_held
);
    localparam int IW = $clog2(KEYS);

    logic [KEYS-1:0] sampled;
    logic [KEYS-1:0] shown;
    logic [KEYS-1:0] delta;
    logic [IW-1:0]   pick;

    assign delta = sampled ^ shown;

    always_comb begin
        pick = '0;
        for (int i = KEYS - 1; i >= 0; i--) begin
            if (delta[i]) pick = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sampled <= '0;
            shown   <= '0;
        end else begin
            if (scan_tick) sampled <= key_state;
            if (|delta) shown[pick] <= sampled[pick];
        end
    end

    assign ev_change          = |delta;
    assign ev_data.key        = KEY_W'(pick);
    assign ev_data.release_ev = ~sampled[pick];
    assign ev_push            = ev_change && (sampled[pick] || rel_en);
    assign quiet_tick         = scan_tick && !ev_change && (key_state == shown);
    assign any_held           = |shown;

endmodule

// File: rtl/kq_repeat.sv
module kq_repeat
    import kq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       quiet_tick,
    input  logic       any_held,
    input  logic       ev_change,
    input  logic       rep_en,
    input  logic [3:0] rep_delay,
    input  logic [2:0] rep_rate,
    output logic       rep_push
);
    logic [7:0] ticks;
    logic       in_rate;
    logic [7:0] target;
    logic       hit;
    logic       active;

    assign target   = in_rate ? next_wait(rep_rate) : first_wait(rep_delay);
    assign active   = rep_en && any_held && !ev_change;
    assign hit      = ({1'b0, ticks} + 9'd1) == {1'b0, target};
    assign rep_push = active && quiet_tick && hit;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            ticks   <= '0;
            in_rate <= 1'b0;
        end else if (quiet_tick) begin
            if (hit) begin
                ticks   <= '0;
                in_rate <= 1'b1;
            end else begin
                ticks <= ticks + 8'd1;
            end
        end
    end

endmodule

// File: rtl/kq_fifo.sv
module kq_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       lost
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic             pop_ok;
    logic             push_ok;

    assign pop_ok  = pop && (count != '0);
    assign push_ok = push && ((count != CW'(DEPTH)) || pop_ok);
    assign lost    = push && !push_ok;
    assign head    = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) slots[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + PW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + PW'(1);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/kq_irq.sv
module kq_irq #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scan_tick,
    input  logic          queued,
    input  logic [CW-1:0] count,
    input  logic          rd_stb,
    input  logic          rd_clr,
    input  logic [4:0]    irq_ticks,
    input  logic [2:0]    irq_level,
    output logic          irq
);
    logic [4:0] elapsed;
    logic       timing;
    logic       level_hit;
    logic       time_hit;
    logic       clear;

    assign level_hit = (irq_level != 3'd0) && (count >= CW'({irq_level, 1'b0}));
    assign time_hit  = timing && scan_tick && ((elapsed + 5'd1) == irq_ticks);
    assign clear     = rd_stb && (rd_clr || (count <= CW'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
            timing  <= 1'b0;
        end else if (queued) begin
            elapsed <= '0;
            timing  <= (irq_ticks != 5'd0);
        end else if (rd_stb && rd_clr) begin
            timing <= 1'b0;
        end else if (timing && scan_tick) begin
            if (time_hit) timing <= 1'b0;
            else          elapsed <= elapsed + 5'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        irq <= 1'b0;
        else if (clear)                 irq <= 1'b0;
        else if (level_hit || time_hit) irq <= 1'b1;
    end

endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
    import kq_pkg::*;
#(
    parameter int KEYS  = KEY_COUNT,
    parameter int DEPTH = Q_DEPTH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scan_tick,
    input  logic [KEYS-1:0] key_state,
    input  logic            rel_en,
    input  logic            rep_en,
    input  logic [3:0]      rep_delay,
    input  logic [2:0]      rep_rate,
    input  logic [4:0]      irq_ticks,
    input  logic [2:0]      irq_level,
    input  logic            rd_clr,
    input  logic            rd_stb,
    output logic [7:0]      rd_data,
    output logic            irq,
    output logic            overflow
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic          scan_push;
    kev_t          scan_ev;
    logic          scan_change;
    logic          quiet;
    logic          held;
    logic          rep_push;
    logic          q_push;
    kev_t          q_din;
    logic [EV_W-1:0] q_head;
    logic [CW-1:0] fifo_count;
    logic          q_lost;

    kq_event_scan #(.KEYS(KEYS)) u_scan (
        .clk        (clk),
        .rst        (rst),
        .scan_tick  (scan_tick),
        .key_state  (key_state),
        .rel_en     (rel_en),
        .ev_push    (scan_push),
        .ev_data    (scan_ev),
        .ev_change  (scan_change),
        .quiet_tick (quiet),
        .any_held   (held)
    );

    kq_repeat u_rep (
        .clk        (clk),
        .rst        (rst),
        .quiet_tick (quiet),
        .any_held   (held),
        .ev_change  (scan_change),
        .rep_en     (rep_en),
        .rep_delay  (rep_delay),
        .rep_rate   (rep_rate),
        .rep_push   (rep_push)
    );

    assign q_push = scan_push || rep_push;
    assign q_din  = rep_push ? REPEAT_EV : scan_ev;

    kq_fifo #(.DEPTH(DEPTH), .WIDTH(EV_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (q_push),
        .din   (q_din),
        .pop   (rd_stb),
        .head  (q_head),
        .count (fifo_count),
        .lost  (q_lost)
    );

    kq_irq #(.CW(CW)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .scan_tick (scan_tick),
        .queued    (q_push),
        .count     (fifo_count),
        .rd_stb    (rd_stb),
        .rd_clr    (rd_clr),
        .irq_ticks (irq_ticks),
        .irq_level (irq_level),
        .irq       (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= IDLE_BYTE;
            overflow <= 1'b0;
        end else begin
            if (q_lost) overflow <= 1'b1;
            if (rd_stb) begin
                if (fifo_count == '0) rd_data <= IDLE_BYTE;
                else                  rd_data <= {fifo_count > CW'(1), q_head};
            end
        end
    end

endmodule

// File: rtl/kq_checker.sv
module kq_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_stb,
    input logic          rd_clr,
    input logic [7:0]    rd_data,
    input logic          irq,
    input logic          overflow,
    input logic [CW-1:0] count
);
    // R11
    queue_cap_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R11
    overflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R11
    overflow_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(count) == CW'(DEPTH));

    // R5
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && count == '0) |=> rd_data == 8'h3F);

    // R2
    more_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && count > CW'(1)) |=> rd_data[7]);

    // R2
    more_flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && count == CW'(1)) |=> !rd_data[7]);

    // R10
    read_clears_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_clr) |=> !irq);

endmodule

bind key_event_queue kq_checker #(.DEPTH(DEPTH), .CW(CW)) u_kq_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_stb   (rd_stb),
    .rd_clr   (rd_clr),
    .rd_data  (rd_data),
    .irq      (irq),
    .overflow (overflow),
    .count    (fifo_count)
);

// File: tb/key_event_queue_test.sv
module key_event_queue_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_tick = 1'b0;
    logic [63:0] key_state = '0;
    logic        rel_en = 1'b1;
    logic        rep_en = 1'b0;
    logic [3:0]  rep_delay = 4'd0;
    logic [2:0]  rep_rate = 3'd0;
    logic [4:0]  irq_ticks = 5'd0;
    logic [2:0]  irq_level = 3'd0;
    logic        rd_clr = 1'b1;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_data;
    logic        irq;
    logic        overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    key_event_queue uut (
        .clk       (clk),
        .rst       (rst),
        .scan_tick (scan_tick),
        .key_state (key_state),
        .rel_en    (rel_en),
        .rep_en    (rep_en),
        .rep_delay (rep_delay),
        .rep_rate  (rep_rate),
        .irq_ticks (irq_ticks),
        .irq_level (irq_level),
        .rd_clr    (rd_clr),
        .rd_stb    (rd_stb),
        .rd_data   (rd_data),
        .irq       (irq),
        .overflow  (overflow)
    );

    // {column, row, expected press byte}
    localparam logic [13:0] VEC [8] = '{
        {3'd0, 3'd0, 8'h00},
        {3'd1, 3'd0, 8'h08},
        {3'd0, 3'd7, 8'h07},
        {3'd7, 3'd7, 8'h3F},
        {3'd3, 3'd5, 8'h1D},
        {3'd5, 3'd2, 8'h2A},
        {3'd2, 3'd6, 8'h16},
        {3'd6, 3'd1, 8'h31}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic do_tick(input logic [63:0] v);
        @(negedge clk);
        key_state = v;
        scan_tick = 1'b1;
        @(negedge clk);
        scan_tick = 1'b0;
        repeat (72) @(negedge clk);
    endtask

    task automatic ticks(input int n, input logic [63:0] v);
        for (int i = 0; i < n; i++) do_tick(v);
    endtask

    task automatic read_byte(output logic [7:0] b);
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        b = rd_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_data", rd_data, 8'h3F);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 overflow", {7'd0, overflow}, 8'h00);

        // R2 table walk: press then release of single keys
        for (int v = 0; v < 8; v++) begin
            held = 64'd1 << (VEC[v][13:11] * 8 + VEC[v][10:8]);
            do_tick(held);
            read_byte(b);
            check("R2 press byte", b, VEC[v][7:0]);
            do_tick('0);
            read_byte(b);
            check("R2 release byte", b, VEC[v][7:0] | 8'h40);
        end

        // R3 two keys same tick, ascending, more flag
        do_tick((64'd1 << 10) | (64'd1 << 3));
        read_byte(b);
        check("R3 first key 3 with more", b, 8'h83);
        read_byte(b);
        check("R3 second key 10", b, 8'h0A);

        // R5 empty reads
        read_byte(b);
        check("R5 empty read", b, 8'h3F);
        read_byte(b);
        check("R5 empty read again", b, 8'h3F);
        do_tick('0);
        read_byte(b);
        check("R2 release key 3 more", b, 8'hC3);
        read_byte(b);
        check("R2 release key 10", b, 8'h4A);

        // R4 releases suppressed
        do_tick(64'd1 << 5);
        read_byte(b);
        check("R4 press still queued", b, 8'h05);
        rel_en = 1'b0;
        do_tick('0);
        read_byte(b);
        check("R4 release not queued", b, 8'h3F);
        rel_en = 1'b1;

        // R6 autorepeat, delay 8, rate 4, two keys held
        rep_en = 1'b1;
        held = 64'h6;
        do_tick(held);
        read_byte(b);
        check("R6 press key 1", b, 8'h81);
        read_byte(b);
        check("R6 press key 2", b, 8'h02);
        ticks(7, held);
        read_byte(b);
        check("R6 no repeat before delay", b, 8'h3F);
        ticks(1, held);
        read_byte(b);
        check("R6 first repeat code", b, 8'h7E);
        read_byte(b);
        check("R6 single code per interval", b, 8'h3F);
        ticks(3, held);
        read_byte(b);
        check("R6 no repeat before rate", b, 8'h3F);
        ticks(1, held);
        read_byte(b);
        check("R6 rate repeat", b, 8'h7E);

        // R7 new press restarts delay
        held = 64'h16;
        do_tick(held);
        read_byte(b);
        check("R7 press key 4", b, 8'h04);
        ticks(7, held);
        read_byte(b);
        check("R7 delay restarted after press", b, 8'h3F);
        ticks(1, held);
        read_byte(b);
        check("R7 repeat after restarted delay", b, 8'h7E);

        // R7 release with keys still held restarts delay
        held = 64'h14;
        do_tick(held);
        read_byte(b);
        check("R7 release key 1", b, 8'h41);
        ticks(7, held);
        read_byte(b);
        check("R7 delay restarted after release", b, 8'h3F);
        ticks(1, held);
        read_byte(b);
        check("R7 repeat after release restart", b, 8'h7E);
        rep_en = 1'b0;
        do_tick('0);
        read_byte(b);
        check("R3 release key 2 first", b, 8'hC2);
        read_byte(b);
        check("R3 release key 4 second", b, 8'h44);

        // R8 level interrupt, R10 clear-on-empty
        rd_clr = 1'b0;
        irq_level = 3'd1;
        do_tick(64'd1);
        check("R8 below level", {7'd0, irq}, 8'h00);
        do_tick('0);
        check("R8 level reached", {7'd0, irq}, 8'h01);
        read_byte(b);
        check("R10 irq held while not empty", {7'd0, irq}, 8'h01);
        read_byte(b);
        check("R10 irq cleared on empty", {7'd0, irq}, 8'h00);
        irq_level = 3'd0;
        rd_clr = 1'b1;

        // R9 time interrupt, R10 read clears
        irq_ticks = 5'd3;
        do_tick(64'd1 << 7);
        check("R9 no irq at event", {7'd0, irq}, 8'h00);
        ticks(2, 64'd1 << 7);
        check("R9 no irq before count", {7'd0, irq}, 8'h00);
        ticks(1, 64'd1 << 7);
        check("R9 irq after count", {7'd0, irq}, 8'h01);
        read_byte(b);
        check("R9 queued press", b, 8'h07);
        check("R10 read clears irq", {7'd0, irq}, 8'h00);
        irq_ticks = 5'd0;
        do_tick('0);
        read_byte(b);
        check("R2 release key 7", b, 8'h47);

        // R11 overflow: 17 presses on one tick
        check("R11 overflow clear before", {7'd0, overflow}, 8'h00);
        do_tick(64'h1FFFF);
        check("R11 overflow set", {7'd0, overflow}, 8'h01);
        for (int i = 0; i < 16; i++) begin
            read_byte(b);
            check("R11 stored entry", b, {(i < 15), 1'b0, 6'(i)});
        end
        read_byte(b);
        check("R11 key 16 dropped", b, 8'h3F);
        check("R11 overflow sticky", {7'd0, overflow}, 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule